// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Access Sequencer

This block sits between a CPU-side bus port and a byte-wide serial engine. Each bus load or store of 1 to 4 bytes that lands in the flash window becomes a complete serial flash byte sequence. The control word of the addressed chip select sets the shape of that sequence. In the three automatic modes (read, fast read, write) the block pulls the chip select low and sends a command byte. It then sends the address, most significant byte first, followed by dummy bytes in fast read only, and then moves the data bytes. At the end it lets the chip select return to its programmed level. In user mode the block only moves the data bytes, and the chip select is left to software through the stop bit of the control word.

The bus request stalls until the whole sequence has finished, and only one access is in flight at a time. The serial engine takes one byte at a time through a valid/ready handshake. The receive byte it returns is valid in the same cycle as its ready.

The controlling state machine has six states. IDLE takes a request. CMD sends the command byte. ADDR sends the address bytes. DUMMY sends the filler bytes. DATA moves the payload. DONE answers the bus for one cycle.
- IDLE→DONE: the request is refused.
- IDLE→DATA: user mode.
- IDLE→CMD: any other mode.
- CMD→ADDR: after the command byte.
- ADDR→DUMMY or ADDR→DATA: after the last address byte, depending on fast read and a non-zero dummy count.
- DUMMY→DATA: after the last dummy byte.
- DATA→DONE: after the last payload byte.
- DONE→IDLE: always.

Top module: `flash_window_seq`

## Requirements
- R1: After reset every chip-select output is high, `req_ready` is low and `xfer_valid` is low.
- R2: Control bits [1:0] select the mode (0 read, 1 fast read, 2 write, 3 user). A store in read or fast-read mode, or a load in write mode, is answered with `resp_err` high and sends no bytes.
- R3: In automatic modes the first byte is the command from control bits [23:16]. In read mode a zero command becomes 0x03. In fast-read or write mode a zero command is answered with `resp_err` and sends no bytes.
- R4: During an automatic-mode sequence the selected chip-select output is low for every byte. When no sequence is running, each chip-select output follows bit 2 (stop) of its control word, one cycle later.
- R5: After the command, the address goes out most significant byte first: 4 bytes (bits 31..0) when `addr4_en[cs]` is set, otherwise 3 bytes (bits 23..0).
- R6: In fast-read mode only, ((bit14<<2)|bits[7:6])×8 dummy bytes follow the address, halved when bit 28 is set. Each dummy byte equals `dummy_byte`.
- R7: Data bytes move least significant first, byte i in bits [8i+7:8i]. Loads send 0x00 and assemble the received bytes into `resp_rdata`, with unused upper bytes zero. Stores send the `req_wdata` bytes.
- R8: A store is refused with `resp_err` and sends no bytes unless bit 16+cs of `conf_reg` is set.
- R9: In user mode only the data bytes are sent, with no command, address or dummy bytes, and the chip select keeps following its stop bit.
- R10: `req_ready` is high for exactly one cycle per request. `xfer_valid` and `xfer_tx` hold steady until `xfer_ready`.
- R11: A `req_size` outside 1..4 is answered with `resp_err` and sends no bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Bus request present, held until `req_ready` |
| req_ready | output | 1 | One-cycle completion pulse |
| req_cs | input | CS_W | Target chip select |
| req_write | input | 1 | 1 store, 0 load |
| req_addr | input | ADDR_W | Byte offset inside the chip-select segment |
| req_size | input | SIZE_W | Access size in bytes |
| req_wdata | input | DATA_W | Store data |
| resp_rdata | output | DATA_W | Load data, valid with `req_ready` |
| resp_err | output | 1 | Request refused, valid with `req_ready` |
| conf_reg | input | 32 | Configuration word (write enables at 16+cs) |
| cs_ctrl | input | NUM_CS*32 | Per-chip-select control words, cs0 lowest |
| addr4_en | input | NUM_CS | Per-chip-select 4-byte address enable |
| dummy_byte | input | 8 | Value sent on dummy bytes |
| xfer_valid | output | 1 | Byte offered to the serial engine |
| xfer_tx | output | 8 | Byte to send |
| xfer_ready | input | 1 | Serial engine finished the byte |
| xfer_rx | input | 8 | Byte received, valid with `xfer_ready` |
| cs_n | output | NUM_CS | Chip-select outputs, active low |

## Verification
The bench sweeps every mode against loads and stores of all four sizes, both address widths and eight dummy settings, some of them halved by the dual bit. A zero command appears at intervals. This separates the default read command from the zero-command refusal, shows a dummy phase that exists only in fast read, and exposes byte-order mistakes on both the address and the data. Stores with the enable bit cleared and out-of-range sizes show that refusal sends no bytes at all. User-mode accesses with the stop bit low and high separate software chip-select control from automatic control, and the idle chip-select level is compared with the stop bits after every access.

// File: rtl/fws_pkg.sv
package fws_pkg;
    typedef enum logic [1:0] {
        MODE_RD   = 2'd0,
        MODE_FRD  = 2'd1,
        MODE_WR   = 2'd2,
        MODE_USER = 2'd3
    } fws_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA, ST_DONE
    } fws_state_e;

    localparam int STOP_BIT   = 2;
    localparam int DLO_LSB    = 6;
    localparam int DHI_BIT    = 14;
    localparam int CMD_LSB    = 16;
    localparam int DUAL_BIT   = 28;
    localparam int WEN_LSB    = 16;
    localparam int CNT_W      = 6;
    localparam logic [7:0] DEFAULT_RD_CMD = 8'h03;

    typedef struct packed {
        logic          err;
        fws_mode_e     mode;
        logic [7:0]    cmd;
        logic [CNT_W-1:0] dummies;
        logic          wide;
    } fws_plan_t;
endpackage

// File: rtl/fws_plan.sv
module fws_plan
    import fws_pkg::*;
#(
    parameter int SIZE_W = 3,
    parameter int MAXB   = 4
) (
    input  logic [31:0]       ctrl_word,
    input  logic              wen,
    input  logic              wide,
    input  logic              is_write,
    input  logic [SIZE_W-1:0] size,
    output fws_plan_t         plan
);
    logic [7:0]       cmd_raw;
    logic [CNT_W-1:0] dum_full;

    always_comb begin
        cmd_raw  = ctrl_word[CMD_LSB +: 8];
        dum_full = {ctrl_word[DHI_BIT], ctrl_word[DLO_LSB +: 2], 3'b000};
        plan.mode    = fws_mode_e'(ctrl_word[1:0]);
        plan.wide    = wide;
        plan.dummies = ctrl_word[DUAL_BIT] ? (dum_full >> 1) : dum_full;
        plan.cmd     = (plan.mode == MODE_RD && cmd_raw == 8'h00) ? DEFAULT_RD_CMD : cmd_raw;
        plan.err     = (size == '0) || (size > SIZE_W'(MAXB))
                     || (is_write && !wen)
                     || (is_write && (plan.mode == MODE_RD || plan.mode == MODE_FRD))
                     || (!is_write && plan.mode == MODE_WR)
                     || ((plan.mode == MODE_FRD || plan.mode == MODE_WR) && cmd_raw == 8'h00);
    end
endmodule

// File: rtl/fws_cs_drive.sv
module fws_cs_drive #(
    parameter int NUM_CS = 2,
    parameter int CS_W   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CS-1:0] stop_bits,
    input  logic              auto_next,
    input  logic [CS_W-1:0]   sel_next,
    output logic [NUM_CS-1:0] cs_n
);
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cs_n[g] <= 1'b1;
            else if (auto_next && sel_next == CS_W'(g))
                cs_n[g] <= 1'b0;
            else
                cs_n[g] <= stop_bits[g];
        end
    end
endmodule

// File: rtl/fws_rx_pack.sv
module fws_rx_pack #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [IDX_W-1:0]  idx,
    input  logic [7:0]        rx_byte,
    output logic [DATA_W-1:0] word
);
    localparam int LANES = DATA_W / 8;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word[8*l +: 8] <= 8'h00;
            else if (clear)
                word[8*l +: 8] <= 8'h00;
            else if (load && idx == IDX_W'(l))
                word[8*l +: 8] <= rx_byte;
        end
    end
endmodule

// File: rtl/flash_window_seq.sv
module flash_window_seq
    import fws_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int MAXB   = DATA_W / 8,
    localparam int SIZE_W = $clog2(MAXB) + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [CS_W-1:0]      req_cs,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [SIZE_W-1:0]    req_size,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic [DATA_W-1:0]    resp_rdata,
    output logic                 resp_err,
    input  logic [31:0]          conf_reg,
    input  logic [NUM_CS*32-1:0] cs_ctrl,
    input  logic [NUM_CS-1:0]    addr4_en,
    input  logic [7:0]           dummy_byte,
    output logic                 xfer_valid,
    output logic [7:0]           xfer_tx,
    input  logic                 xfer_ready,
    input  logic [7:0]           xfer_rx,
    output logic [NUM_CS-1:0]    cs_n
);
    localparam int IDX_W = $clog2(MAXB);

    fws_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    fws_plan_t         plan_live, plan_q;
    logic [CS_W-1:0]   cs_q;
    logic              write_q;
    logic [ADDR_W-1:0] addr_q;
    logic [SIZE_W-1:0] size_q;
    logic [DATA_W-1:0] wdata_q;
    logic              accept;
    logic [NUM_CS-1:0] stop_bits;
    logic [2:0]        nab;
    logic [1:0]        ab_sel;
    logic              auto_next;
    fws_mode_e         mode_next;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_stop
        assign stop_bits[g] = cs_ctrl[32*g + STOP_BIT];
    end

    fws_plan #(.SIZE_W(SIZE_W), .MAXB(MAXB)) u_plan (
        .ctrl_word (cs_ctrl[32*req_cs +: 32]),
        .wen       (conf_reg[WEN_LSB + int'(req_cs)]),
        .wide      (addr4_en[req_cs]),
        .is_write  (req_write),
        .size      (req_size),
        .plan      (plan_live)
    );

    assign accept = (state_q == ST_IDLE) && req_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            plan_q  <= '0;
            cs_q    <= '0;
            write_q <= 1'b0;
            addr_q  <= '0;
            size_q  <= '0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (accept) begin
                plan_q  <= plan_live;
                cs_q    <= req_cs;
                write_q <= req_write;
                addr_q  <= req_addr;
                size_q  <= req_size;
                wdata_q <= req_wdata;
            end
        end
    end

    assign nab = plan_q.wide ? 3'd4 : 3'd3;

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (req_valid) begin
                    if (plan_live.err)                 state_d = ST_DONE;
                    else if (plan_live.mode == MODE_USER) state_d = ST_DATA;
                    else                               state_d = ST_CMD;
                end
            end
            ST_CMD: if (xfer_ready) begin
                state_d = ST_ADDR;
                cnt_d   = '0;
            end
            ST_ADDR: if (xfer_ready) begin
                if (cnt_q == CNT_W'(nab - 3'd1)) begin
                    cnt_d   = '0;
                    state_d = (plan_q.mode == MODE_FRD && plan_q.dummies != '0) ? ST_DUMMY : ST_DATA;
                end else cnt_d = cnt_q + 1'b1;
            end
            ST_DUMMY: if (xfer_ready) begin
                if (cnt_q == plan_q.dummies - 1'b1) begin
                    cnt_d   = '0;
                    state_d = ST_DATA;
                end else cnt_d = cnt_q + 1'b1;
            end
            ST_DATA: if (xfer_ready) begin
                if (cnt_q == CNT_W'(size_q) - 1'b1) state_d = ST_DONE;
                else cnt_d = cnt_q + 1'b1;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ab_sel     = 2'(nab - 3'd1 - 3'(cnt_q));
        xfer_valid = 1'b0;
        xfer_tx    = 8'h00;
        req_ready  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_CMD:   begin xfer_valid = 1'b1; xfer_tx = plan_q.cmd; end
            ST_ADDR:  begin xfer_valid = 1'b1; xfer_tx = addr_q[8*ab_sel +: 8]; end
            ST_DUMMY: begin xfer_valid = 1'b1; xfer_tx = dummy_byte; end
            ST_DATA:  begin
                xfer_valid = 1'b1;
                xfer_tx    = write_q ? wdata_q[8*cnt_q[IDX_W-1:0] +: 8] : 8'h00;
            end
            ST_DONE:  req_ready = 1'b1;
            default:  ;
        endcase
    end

    assign resp_err  = plan_q.err;
    assign mode_next = (state_q == ST_IDLE) ? plan_live.mode : plan_q.mode;
    assign auto_next = (state_d inside {ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA}) && (mode_next != MODE_USER);

    fws_cs_drive #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_cs (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_bits (stop_bits),
        .auto_next (auto_next),
        .sel_next  ((state_q == ST_IDLE) ? req_cs : cs_q),
        .cs_n      (cs_n)
    );

    fws_rx_pack #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .load    (state_q == ST_DATA && xfer_ready && !write_q),
        .idx     (cnt_q[IDX_W-1:0]),
        .rx_byte (xfer_rx),
        .word    (resp_rdata)
    );

    a_r10_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_tx));
    a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);
    a_r4_cs_low_auto: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid && plan_q.mode != MODE_USER |-> !cs_n[cs_q]);
    a_r8_refuse_store: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE && req_valid && req_write && !conf_reg[WEN_LSB + int'(req_cs)]
        |=> req_ready && resp_err && !xfer_valid);
    a_r3_cmd_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_CMD |-> xfer_tx != 8'h00);
endmodule

// File: tb/flash_window_seq_tb.sv
module flash_window_seq_tb;
    localparam int NUM_CS = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [0:0]  req_cs = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] resp_rdata;
    logic        resp_err;
    logic [31:0] conf_reg = '0;
    logic [63:0] cs_ctrl = '0;
    logic [1:0]  addr4_en = '0;
    logic [7:0]  dummy_byte = '0;
    logic        xfer_valid;
    logic [7:0]  xfer_tx;
    logic        xfer_ready = 1'b0;
    logic [7:0]  xfer_rx = '0;
    logic [1:0]  cs_n;

    int tests = 0, fails = 0;
    bit done = 0;

    logic [7:0] log_b [0:127];
    logic [1:0] log_cs [0:127];
    int         log_n = 0;
    logic [7:0] exp_b [0:127];
    int         exp_n;

    always #4 clk = ~clk;

    flash_window_seq #(.NUM_CS(NUM_CS)) u_dut (.*);

    function automatic logic [7:0] rx_of(int i);
        return 8'h3C + 8'(i * 13);
    endfunction

    // serial engine model: one byte per two cycles
    initial begin
        forever begin
            @(negedge clk);
            if (xfer_ready) xfer_ready = 1'b0;
            else if (xfer_valid) begin
                if (log_n < 128) begin
                    log_b[log_n]  = xfer_tx;
                    log_cs[log_n] = cs_n;
                end
                xfer_rx    = rx_of(log_n);
                log_n      = log_n + 1;
                xfer_ready = 1'b1;
            end
        end
    end

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ctrl(int mode, logic [7:0] cmd, bit stop, int dsel, bit dual);
        logic [31:0] w = '0;
        w[1:0]   = 2'(mode);
        w[2]     = stop;
        w[7:6]   = 2'(dsel);
        w[14]    = 1'((dsel >> 2) & 1);
        w[23:16] = cmd;
        w[28]    = dual;
        return w;
    endfunction

    task automatic access(input int cs, input bit wr, input logic [31:0] addr, input int size, input logic [31:0] wd);
        logic [31:0] c;
        int mode, nd;
        bit eerr;
        logic [31:0] erd;
        logic [1:0] idle_cs;
        c    = cs_ctrl[32*cs +: 32];
        mode = int'(c[1:0]);
        eerr = (size < 1) || (size > 4) || (wr && !conf_reg[16+cs])
            || (wr && mode < 2) || (!wr && mode == 2)
            || ((mode == 1 || mode == 2) && c[23:16] == 8'h00);
        exp_n = 0;
        erd   = '0;
        if (!eerr) begin
            if (mode != 3) begin
                exp_b[exp_n++] = (mode == 0 && c[23:16] == 0) ? 8'h03 : c[23:16];
                if (addr4_en[cs]) exp_b[exp_n++] = addr[31:24];
                exp_b[exp_n++] = addr[23:16];
                exp_b[exp_n++] = addr[15:8];
                exp_b[exp_n++] = addr[7:0];
                if (mode == 1) begin
                    nd = ((int'(c[14]) << 2) | int'(c[7:6])) * 8;
                    if (c[28]) nd = nd / 2;
                    for (int k = 0; k < nd; k++) exp_b[exp_n++] = dummy_byte;
                end
            end
            for (int k = 0; k < size; k++) begin
                exp_b[exp_n] = wr ? wd[8*k +: 8] : 8'h00;
                if (!wr) erd[8*k +: 8] = rx_of(exp_n);
                exp_n++;
            end
        end
        log_n = 0;
        @(negedge clk);
        req_valid = 1'b1; req_cs = 1'(cs); req_write = wr;
        req_addr = addr; req_size = 4'(size); req_wdata = wd;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        // R2 R3 R8 R11: error response
        check(resp_err == eerr, $sformatf("R2 R3 R8 R11 err mode=%0d wr=%0d size=%0d", mode, wr, size), 64'(resp_err), 64'(eerr));
        if (!eerr && !wr)  // R7: load data assembly
            check(resp_rdata == erd, "R7 rdata", 64'(resp_rdata), 64'(erd));
        req_valid = 1'b0;
        @(negedge clk);
        // R3 R5 R6 R7 R9: byte sequence and R4 chip select per byte
        begin
            bit ok = (log_n == exp_n);
            int bad = -1;
            for (int k = 0; k < exp_n && k < log_n; k++) begin
                logic [1:0] want_cs;
                want_cs = (mode == 3) ? {cs_ctrl[34], cs_ctrl[2]} : ~(2'b01 << cs);
                if (mode != 3) want_cs = want_cs & {cs_ctrl[34], cs_ctrl[2]} | ~(2'b01 << cs) & 2'b00 | want_cs;
                if (log_b[k] !== exp_b[k] || (mode != 3 && log_cs[k][cs] !== 1'b0)
                    || (mode == 3 && log_cs[k][cs] !== c[2])) begin
                    ok = 0; if (bad < 0) bad = k;
                end
            end
            check(ok, $sformatf("R3 R4 R5 R6 R7 R9 sequence mode=%0d wr=%0d size=%0d len=%0d/%0d at %0d",
                  mode, wr, size, log_n, exp_n, bad), (bad >= 0) ? 64'(log_b[bad]) : 64'(log_n),
                  (bad >= 0) ? 64'(exp_b[bad]) : 64'(exp_n));
        end
        idle_cs = {cs_ctrl[34], cs_ctrl[2]};
        check(cs_n == idle_cs, "R4 idle chip select follows stop bits", 64'(cs_n), 64'(idle_cs));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(cs_n == 2'b11 && !req_ready && !xfer_valid, "R1 reset state",
              64'({cs_n, req_ready, xfer_valid}), 64'({2'b11, 1'b0, 1'b0}));
        rst_n = 1'b1;
        conf_reg = 32'h0003_0000;
        dummy_byte = 8'hA5;
        // near-exhaustive sweep
        begin
            int it = 0;
            for (int m = 0; m < 4; m++)
                for (int wr = 0; wr < 2; wr++)
                    for (int sz = 1; sz <= 4; sz++)
                        for (int a4 = 0; a4 < 2; a4++) begin
                            int cs = it % 2;
                            logic [7:0] cmd = (it % 5 == 0) ? 8'h00 : 8'(8'h0B + it);
                            cs_ctrl[32*cs +: 32] = mk_ctrl(m, cmd, (m == 3) ? 1'(it % 3 == 0) : 1'b1,
                                                           it % 8, 1'(it % 16 >= 8));
                            cs_ctrl[32*(1-cs) +: 32] = mk_ctrl(0, 8'h00, 1'b1, 0, 1'b0);
                            addr4_en = 2'(a4 << cs);
                            access(cs, 1'(wr), 32'hA1B2C3D4 ^ (32'(it) * 32'h01030507), sz, 32'h11223344 + 32'(it));
                            it++;
                        end
        end
        // R8: store refused when enable bit clear
        conf_reg = 32'h0001_0000;
        cs_ctrl[32 +: 32] = mk_ctrl(2, 8'h02, 1'b1, 0, 1'b0);
        access(1, 1'b1, 32'h0000_1234, 4, 32'hDEADBEEF);
        conf_reg = 32'h0003_0000;
        access(1, 1'b1, 32'h0000_1234, 4, 32'hDEADBEEF);
        // R11: bad sizes
        cs_ctrl[0 +: 32] = mk_ctrl(0, 8'h00, 1'b1, 0, 1'b0);
        access(0, 1'b0, 32'h40, 0, 0);
        access(0, 1'b0, 32'h40, 5, 0);
        // R9: user mode with software-held select
        cs_ctrl[0 +: 32] = mk_ctrl(3, 8'h00, 1'b0, 0, 1'b0);
        access(0, 1'b1, 32'h0, 2, 32'h0000_9F05);
        access(0, 1'b0, 32'h0, 3, 0);
        cs_ctrl[0 +: 32] = mk_ctrl(3, 8'h00, 1'b1, 0, 1'b0);
        repeat (2) @(negedge clk);
        check(cs_n[0] == 1'b1, "R9 user select released by stop bit", 64'(cs_n[0]), 64'd1);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule